// File: doc/BRIEF.md
# SPI Serial Clock Prescaler

This block derives the serial clock of an SPI master from a fast main clock. The main clock first passes through a power-of-two predivider whose ratio is 2, 4, 8 or 16. A second counter then counts the resulting ticks, and SCK toggles once every (BRG+1) of those ticks. The full SCK period is therefore (2 << DIV) * 2 * (BRG+1) main-clock cycles. The BRG setting has a floor of 4, so the fastest SCK is the main clock divided by 20 and the slowest is the main clock divided by 2048.

The shift engine holds `en` high for the length of a word. While `en` is low, SCK rests at the level the polarity input selects. The divider settings, the polarity and the edge select are captured on every cycle in which the block is disabled, and they are frozen while it runs. Each SCK transition comes with a one-cycle strobe that tells the shift engine whether to sample or to shift. The edge-select input is the inverse of CPHA: when it is set, data is sampled on the first edge of each bit.

Top module: `spi_clk_prescaler`

## Requirements
- R1: While reset is asserted, `sck`, `shift_stb` and `sample_stb` are all 0.
- R2: One cycle after a clock edge at which `en` is low, `sck` equals `cpol` and both strobes are 0.
- R3: Let H = (2 << `div_sel`) * (`brg_val` + 1). The first `sck` transition after `en` rises comes exactly H main-clock cycles after the first enabled clock edge. Every later transition comes H cycles after the one before it.
- R4: A `brg_val` below 4 gives the same half-period as `brg_val` = 4.
- R5: With `div_sel`=0 and `brg_val`=4, the full SCK period is 20 cycles. With `div_sel`=3 and `brg_val`=63, it is 2048 cycles.
- R6: Changes to `div_sel`, `brg_val`, `cpol` or `first_edge_sample` made while `en` is high do not change the running clock. They take effect at the next enable.
- R7: The leading edge is the transition away from the idle level, and the trailing edge is the transition back to it. With `first_edge_sample`=1, `sample_stb` marks each leading edge and `shift_stb` marks each trailing edge. With `first_edge_sample`=0, the two roles are swapped.
- R8: Each strobe is high for exactly one cycle, and only in the cycle right after an `sck` transition. The two strobes are never high together.
- R9: Dropping `en` in the middle of a half-period returns `sck` to idle on the next edge, and no strobe follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | High while a word is in progress |
| div_sel | input | DIV_W | Predivider select; ratio is 2 << div_sel |
| brg_val | input | BRG_W | Second-stage count; half-period is brg_val+1 predivided ticks |
| cpol | input | 1 | Idle level of SCK |
| first_edge_sample | input | 1 | 1: sample on the leading edge (CPHA=0); 0: sample on the trailing edge |
| sck | output | 1 | Serial clock |
| shift_stb | output | 1 | One-cycle pulse: shift out the next bit |
| sample_stb | output | 1 | One-cycle pulse: sample the incoming bit |

## Verification
Two events can meet on the same clock edge. One is an SCK transition, which raises a strobe. The other is the fall of `en`, which forces SCK back to idle and clears the strobes. The bench drops `en` right after a leading edge, in the middle of a half-period. It then checks that the next cycle shows the idle level with both strobes low, and that no late pulse appears over the following cycles. A further check changes the divider settings while the block is running. The bench judges it by the measured half-period, which must be the one captured at enable, while the new value must appear after a disable and re-enable.

// File: rtl/spi_presc_pkg.sv
package spi_presc_pkg;

  localparam int unsigned DIV_W_DEF     = 2;
  localparam int unsigned BRG_W_DEF     = 6;
  localparam int unsigned BRG_FLOOR_DEF = 4;

  typedef enum logic {
    EDGE_LEAD  = 1'b0,
    EDGE_TRAIL = 1'b1
  } edge_kind_e;

endpackage

// File: rtl/spi_presc_cfg.sv
module spi_presc_cfg #(
  parameter int unsigned DIV_W     = 2,
  parameter int unsigned BRG_W     = 6,
  parameter int unsigned BRG_FLOOR = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div_i,
  input  logic [BRG_W-1:0] brg_i,
  input  logic             cpol_i,
  input  logic             first_i,
  output logic [DIV_W-1:0] div_q,
  output logic [BRG_W-1:0] brg_q,
  output logic             cpol_q,
  output logic             first_q
);

  localparam logic [BRG_W-1:0] BRG_MIN = BRG_W'(BRG_FLOOR);

  logic [DIV_W-1:0] div_d;
  logic [BRG_W-1:0] brg_d;
  logic             cpol_d;
  logic             first_d;
  logic             load;

  assign load = !run;

  always_comb begin
    div_d   = div_q;
    brg_d   = brg_q;
    cpol_d  = cpol_q;
    first_d = first_q;
    if (load) begin
      div_d   = div_i;
      brg_d   = (brg_i < BRG_MIN) ? BRG_MIN : brg_i;
      cpol_d  = cpol_i;
      first_d = first_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q   <= '0;
      brg_q   <= BRG_MIN;
      cpol_q  <= 1'b0;
      first_q <= 1'b0;
    end else begin
      div_q   <= div_d;
      brg_q   <= brg_d;
      cpol_q  <= cpol_d;
      first_q <= first_d;
    end
  end

endmodule

// File: rtl/spi_presc_pre.sv
module spi_presc_pre #(
  parameter int unsigned DIV_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);

  localparam int unsigned NUM_DIV = 1 << DIV_W;
  localparam int unsigned CNT_W   = NUM_DIV;

  logic [CNT_W-1:0] term_tbl [NUM_DIV];
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             at_term;

  for (genvar g = 0; g < NUM_DIV; g++) begin : g_term
    assign term_tbl[g] = CNT_W'((64'd2 << g) - 64'd1);
  end

  assign at_term = (cnt_q == term_tbl[div]);
  assign tick    = run && at_term;

  always_comb begin
    cnt_d = cnt_q;
    if (!run) begin
      cnt_d = '0;
    end else if (at_term) begin
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/spi_presc_brg.sv
module spi_presc_brg #(
  parameter int unsigned BRG_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             pre_tick,
  input  logic [BRG_W-1:0] brg,
  output logic             half_tick
);

  logic [BRG_W-1:0] cnt_q;
  logic [BRG_W-1:0] cnt_d;
  logic             at_term;

  assign at_term   = (cnt_q == brg);
  assign half_tick = pre_tick && at_term;

  always_comb begin
    cnt_d = cnt_q;
    if (!run) begin
      cnt_d = '0;
    end else if (pre_tick) begin
      cnt_d = at_term ? '0 : cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/spi_presc_edge.sv
module spi_presc_edge
  import spi_presc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic half_tick,
  input  logic cpol_live,
  input  logic cpol_q,
  input  logic first_q,
  output logic sck,
  output logic shift_stb,
  output logic sample_stb
);

  logic       sck_q, sck_d;
  logic       shift_q, shift_d;
  logic       sample_q, sample_d;
  edge_kind_e kind;
  logic       is_sample;

  assign kind      = (sck_q == cpol_q) ? EDGE_LEAD : EDGE_TRAIL;
  assign is_sample = ((kind == EDGE_LEAD) == first_q);

  always_comb begin
    sck_d    = sck_q;
    shift_d  = 1'b0;
    sample_d = 1'b0;
    if (!run) begin
      sck_d = cpol_live;
    end else if (half_tick) begin
      sck_d    = !sck_q;
      sample_d = is_sample;
      shift_d  = !is_sample;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q    <= 1'b0;
      shift_q  <= 1'b0;
      sample_q <= 1'b0;
    end else begin
      sck_q    <= sck_d;
      shift_q  <= shift_d;
      sample_q <= sample_d;
    end
  end

  assign sck        = sck_q;
  assign shift_stb  = shift_q;
  assign sample_stb = sample_q;

endmodule

// File: rtl/spi_clk_prescaler.sv
module spi_clk_prescaler
  import spi_presc_pkg::*;
#(
  parameter int unsigned DIV_W     = DIV_W_DEF,
  parameter int unsigned BRG_W     = BRG_W_DEF,
  parameter int unsigned BRG_FLOOR = BRG_FLOOR_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [DIV_W-1:0] div_sel,
  input  logic [BRG_W-1:0] brg_val,
  input  logic             cpol,
  input  logic             first_edge_sample,
  output logic             sck,
  output logic             shift_stb,
  output logic             sample_stb
);

  logic [DIV_W-1:0] div_q;
  logic [BRG_W-1:0] brg_q;
  logic             cpol_q;
  logic             first_q;
  logic             pre_tick;
  logic             half_tick;

  spi_presc_cfg #(.DIV_W(DIV_W), .BRG_W(BRG_W), .BRG_FLOOR(BRG_FLOOR)) u_cfg (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (en),
    .div_i   (div_sel),
    .brg_i   (brg_val),
    .cpol_i  (cpol),
    .first_i (first_edge_sample),
    .div_q   (div_q),
    .brg_q   (brg_q),
    .cpol_q  (cpol_q),
    .first_q (first_q)
  );

  spi_presc_pre #(.DIV_W(DIV_W)) u_pre (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (en),
    .div   (div_q),
    .tick  (pre_tick)
  );

  spi_presc_brg #(.BRG_W(BRG_W)) u_brg (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (en),
    .pre_tick  (pre_tick),
    .brg       (brg_q),
    .half_tick (half_tick)
  );

  spi_presc_edge u_edge (
    .clk        (clk),
    .rst_n      (rst_n),
    .run        (en),
    .half_tick  (half_tick),
    .cpol_live  (cpol),
    .cpol_q     (cpol_q),
    .first_q    (first_q),
    .sck        (sck),
    .shift_stb  (shift_stb),
    .sample_stb (sample_stb)
  );

endmodule

// File: rtl/spi_clk_prescaler_chk.sv
module spi_clk_prescaler_chk (
  input logic clk,
  input logic rst_n,
  input logic en,
  input logic cpol,
  input logic sck,
  input logic shift_stb,
  input logic sample_stb
);

  // R8: the two strobes never coincide
  a_r8_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(shift_stb && sample_stb));

  // R8: a shift pulse lasts one cycle
  a_r8_shift_single: assert property (@(posedge clk) disable iff (!rst_n)
    shift_stb |=> !shift_stb);

  // R8: a sample pulse lasts one cycle
  a_r8_sample_single: assert property (@(posedge clk) disable iff (!rst_n)
    sample_stb |=> !sample_stb);

  // R8: a strobe only follows an SCK transition
  a_r8_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_stb || sample_stb) |-> !$stable(sck));

  // R2 / R9: disabled edge leads to idle level with quiet strobes
  a_r9_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (sck == $past(cpol)) && !shift_stb && !sample_stb);

  // R3: no edge strobe at the first enabled edge
  a_r3_no_early_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> en |=> (!shift_stb && !sample_stb));

endmodule

bind spi_clk_prescaler spi_clk_prescaler_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .en         (en),
  .cpol       (cpol),
  .sck        (sck),
  .shift_stb  (shift_stb),
  .sample_stb (sample_stb)
);

// File: tb/spi_clk_prescaler_tb.sv
`timescale 1ns/1ps
module spi_clk_prescaler_tb;

  logic       clk;
  logic       rst_n;
  logic       en;
  logic [1:0] div_sel;
  logic [5:0] brg_val;
  logic       cpol;
  logic       first_edge_sample;
  logic       sck;
  logic       shift_stb;
  logic       sample_stb;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  spi_clk_prescaler u_dut (
    .clk               (clk),
    .rst_n             (rst_n),
    .en                (en),
    .div_sel           (div_sel),
    .brg_val           (brg_val),
    .cpol              (cpol),
    .first_edge_sample (first_edge_sample),
    .sck               (sck),
    .shift_stb         (shift_stb),
    .sample_stb        (sample_stb)
  );

  initial clk = 1'b0;
  always #2.5 clk = !clk;

  // columns: div, brg, cpol, first_edge_sample, expected half-period
  localparam int NVEC = 7;
  localparam int VEC [NVEC][5] = '{
    '{0,  4, 0, 1,   10},
    '{1,  5, 1, 0,   24},
    '{2,  0, 0, 0,   40},
    '{0, 63, 1, 1,  128},
    '{3, 63, 0, 1, 1024},
    '{0,  3, 1, 0,   10},
    '{3,  7, 1, 1,  128}
  };

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic setup(input int dv, input int bg, input bit cp, input bit fe);
    @(negedge clk);
    en = 1'b0;
    div_sel = 2'(dv);
    brg_val = 6'(bg);
    cpol = cp;
    first_edge_sample = fe;
    @(negedge clk);
    @(negedge clk);
  endtask

  // enable, measure two half-periods, check strobes; returns full period
  task automatic run_word(input int exp_half, input bit cp, input bit fe,
                          input string tag, output int total);
    int n;
    int m;
    en = 1'b1;
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (sck == cp && n < 5000);
    chk(n == exp_half, {tag, " R3 first half"}, n, exp_half);
    chk(sample_stb == fe && shift_stb == !fe, {tag, " R7 leading strobe"},
        {30'd0, sample_stb, shift_stb}, fe ? 2 : 1);
    @(negedge clk);
    chk(!sample_stb && !shift_stb, {tag, " R8 pulse width"},
        {30'd0, sample_stb, shift_stb}, 0);
    m = 1;
    while (sck != cp && m < 5000) begin
      @(negedge clk);
      m++;
    end
    chk(m == exp_half, {tag, " R3 second half"}, m, exp_half);
    chk(sample_stb == !fe && shift_stb == fe, {tag, " R7 trailing strobe"},
        {30'd0, sample_stb, shift_stb}, fe ? 1 : 2);
    total = n + m;
  endtask

  initial begin
    int tot;
    rst_n = 1'b0;
    en = 1'b0;
    div_sel = '0;
    brg_val = 6'd4;
    cpol = 1'b1;
    first_edge_sample = 1'b1;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(sck == 1'b0 && !shift_stb && !sample_stb, "R1 reset outputs",
        {29'd0, sck, shift_stb, sample_stb}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk(sck == 1'b1, "R2 idle high", sck, 1);

    for (int i = 0; i < NVEC; i++) begin
      setup(VEC[i][0], VEC[i][1], VEC[i][2][0], VEC[i][3][0]);
      chk(sck == VEC[i][2][0] && !shift_stb && !sample_stb, "R2 idle level",
          sck, VEC[i][2]);
      run_word(VEC[i][4], VEC[i][2][0], VEC[i][3][0],
               (VEC[i][1] < 4) ? "R4 clamp" : "vec", tot);
      chk(tot == 2 * VEC[i][4], "R3 period", tot, 2 * VEC[i][4]);
    end

    // R5: extreme ratios
    setup(0, 4, 0, 0);
    run_word(10, 1'b0, 1'b0, "R5 fast", tot);
    chk(tot == 20, "R5 fastest period", tot, 20);
    setup(3, 63, 1, 1);
    run_word(1024, 1'b1, 1'b1, "R5 slow", tot);
    chk(tot == 2048, "R5 slowest period", tot, 2048);

    // R6: settings changed while running are ignored until re-enable
    setup(0, 4, 0, 1);
    en = 1'b1;
    @(negedge clk);
    div_sel = 2'd3;
    brg_val = 6'd63;
    cpol = 1'b1;
    first_edge_sample = 1'b0;
    begin
      int n;
      n = 1;
      while (sck == 1'b0 && n < 5000) begin
        @(negedge clk);
        n++;
      end
      chk(n == 10, "R6 frozen half-period", n, 10);
      chk(sample_stb && !shift_stb, "R6 frozen edge select",
          {30'd0, sample_stb, shift_stb}, 2);
    end
    @(negedge clk);
    en = 1'b0;
    @(negedge clk);
    chk(sck == 1'b1, "R6 new idle after disable", sck, 1);
    @(negedge clk);
    run_word(1024, 1'b1, 1'b0, "R6 applied", tot);

    // R9: disable mid half-period after a leading edge
    setup(1, 4, 0, 1);
    en = 1'b1;
    begin
      int n;
      n = 0;
      do begin
        @(negedge clk);
        n++;
      end while (sck == 1'b0 && n < 5000);
    end
    @(negedge clk);
    @(negedge clk);
    en = 1'b0;
    @(negedge clk);
    chk(sck == 1'b0 && !shift_stb && !sample_stb, "R9 return to idle",
        {29'd0, sck, shift_stb, sample_stb}, 0);
    begin
      int bad;
      bad = 0;
      for (int k = 0; k < 40; k++) begin
        @(negedge clk);
        if (sck || shift_stb || sample_stb) bad++;
      end
      chk(bad == 0, "R9 quiet after disable", bad, 0);
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

endmodule